// File: doc/BRIEF.md
# Cost-Weighted Multicore Work Dispatcher

This controller sits between a producer of typed work items and a group of cores. Each core has two work buffers. The core executes from its active buffer while the dispatcher fills its other buffer, the pending buffer. Every item that arrives carries a type. The dispatcher looks up the execution cost of that type, in clock cycles, from a table that software can write. It then sends the item to the enabled core whose pending buffer holds the fewest accumulated cycles. The item is never written into an active buffer.

The dispatcher keeps a count of items for each core's active and pending buffers, and a cycle load for each pending buffer. Cores report each finished item with a one-cycle pulse. Once every active buffer is empty and some pending buffer has work, the dispatcher sends a one-cycle exchange pulse to all cores at once. On that pulse the pending buffers become the active buffers. At the same pulse the dispatcher works out how many cores the new batch needs from the total pending cycles and a programmable per-core budget. The cores above that number are disabled until the next exchange.

Top module: `load_dispatcher`

## Requirements
- R1: While reset is held and in the first cycle after it, all item counts and pending loads are zero, every core is enabled, `swap` is low and `cell_ready` is high. Every cost table entry resets to 1.
- R2: When `cost_we` is high at a clock edge, `cost_wdata` becomes the cost of type `cost_addr`. Items accepted in that same cycle still use the old cost.
- R3: An accepted item (`cell_valid` and `cell_ready` high) goes to the eligible core with the smallest pending load, and ties go to the lowest index. `cell_dest` is the one-hot code of that core (bit i = core i) in the same cycle, and it is zero when no item is accepted.
- R4: At the edge that accepts an item, the chosen core's pending count rises by one and its pending load rises by the item type's cost.
- R5: A core whose pending count equals `DEPTH` is not eligible. When no enabled core is eligible, `cell_ready` is low.
- R6: A pulse on `a_done[i]` lowers core i's active count by one. The pulse is ignored when that count is already zero.
- R7: `swap` is high for exactly one cycle when every active count is zero and at least one pending count is nonzero. At that edge each active count takes the pending count, pending counts and loads are cleared, and `cell_ready` is low in that cycle.
- R8: At a swap edge the number of enabled cores becomes ceil(sum of pending loads / `cycle_budget`), limited to between 1 and `NCORES`. A budget of 0 with nonzero load enables all cores. Cores 0 up to that number minus one are enabled (`core_en` bit i = core i). `core_en` changes only at a swap edge.
- R9: A disabled core is never chosen for an item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cost_we | input | 1 | Cost table write strobe |
| cost_addr | input | TYPE_W | Item type whose cost is written |
| cost_wdata | input | COST_W | New cost in cycles |
| cycle_budget | input | SUM_W | Cycles one core is expected to carry per batch |
| cell_valid | input | 1 | An item is offered |
| cell_type | input | TYPE_W | Type of the offered item |
| cell_ready | output | 1 | Dispatcher can take an item this cycle |
| cell_dest | output | NCORES | One-hot write strobe into the chosen pending buffer |
| a_done | input | NCORES | Per-core pulse: one active item finished |
| swap | output | 1 | Exchange pulse to all cores |
| core_en | output | NCORES | Core enable mask |
| a_count | output | NCORES*CNT_W | Active item count per core |
| b_count | output | NCORES*CNT_W | Pending item count per core |
| b_load | output | NCORES*LOAD_W | Pending cycle load per core |

## Verification
The bench targets load ties, which must resolve to the lowest index. A picker that compared with less-or-equal would send tied work to the highest core instead. It fills pending buffers until no enabled core has room. A design that ignored fullness would push a count past `DEPTH`, and one that kept `cell_ready` high would accept an item with nowhere to go. It writes costs while items are flowing, pulses `a_done` on cores whose active count is already zero, and moves the budget from tiny to huge. An off-by-one in the rounded division, or a missing clamp to one core, would show up as a wrong `core_en` after the exchange. Letting an item through on the exchange cycle would leave a stray count in a pending buffer that has just been cleared.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

   // Width of a counter that must hold 0..depth inclusive.
   function automatic int cnt_width(input int depth);
      return (depth < 1) ? 1 : $clog2(depth + 1);
   endfunction

   // Width of a pending-load accumulator for one core.
   function automatic int load_width(input int cost_w, input int depth);
      return cost_w + cnt_width(depth);
   endfunction

   // Width of the sum of all cores' loads.
   function automatic int sum_width(input int cost_w, input int depth, input int ncores);
      return load_width(cost_w, depth) + ((ncores < 2) ? 1 : $clog2(ncores));
   endfunction

endpackage

// File: rtl/dsp_cost_table.sv
module dsp_cost_table
   import dispatch_pkg::*;
#(
   parameter int NTYPES     = 8,
   parameter int COST_W     = 16,
   parameter int RESET_COST = 1,
   localparam int TYPE_W    = $clog2(NTYPES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [TYPE_W-1:0] waddr,
   input  logic [COST_W-1:0] wdata,
   input  logic [TYPE_W-1:0] raddr,
   output logic [COST_W-1:0] rdata
);

   localparam bit FULL_RANGE = (NTYPES == (1 << TYPE_W));

   logic [COST_W-1:0] cost_q [NTYPES];
   logic              wr_hit;

   generate
      if (FULL_RANGE) begin : g_full
         assign wr_hit = we;
         assign rdata  = cost_q[raddr];
      end else begin : g_sparse
         assign wr_hit = we && (int'(waddr) < NTYPES);
         assign rdata  = (int'(raddr) < NTYPES) ? cost_q[raddr] : '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < NTYPES; t++) cost_q[t] <= COST_W'(RESET_COST);
      end else if (wr_hit) begin
         cost_q[waddr] <= wdata;
      end
   end

   AST_COST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> cost_q[$past(waddr)] == $past(wdata)) else $error("cost write lost"); // R2

endmodule

// File: rtl/dsp_core_track.sv
module dsp_core_track
   import dispatch_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int COST_W  = 16,
   localparam int CNT_W  = cnt_width(DEPTH),
   localparam int LOAD_W = load_width(COST_W, DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [COST_W-1:0] cost,
   input  logic              done,
   input  logic              swap,
   output logic [CNT_W-1:0]  a_cnt,
   output logic [CNT_W-1:0]  b_cnt,
   output logic [LOAD_W-1:0] b_load
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt  <= '0;
         b_cnt  <= '0;
         b_load <= '0;
      end else if (swap) begin
         a_cnt  <= b_cnt;
         b_cnt  <= '0;
         b_load <= '0;
      end else begin
         if (done && (a_cnt != '0)) a_cnt <= a_cnt - 1'b1;
         if (accept) begin
            b_cnt  <= b_cnt + 1'b1;
            b_load <= b_load + LOAD_W'(cost);
         end
      end
   end

   AST_B_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      b_cnt <= CNT_W'(DEPTH)) else $error("pending count over depth"); // R5

   AST_A_TAKES_B: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> (a_cnt == $past(b_cnt)) && (b_cnt == '0) && (b_load == '0)) else $error("exchange lost counts"); // R7

   AST_A_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (a_cnt == '0 && done && !swap) |=> a_cnt == '0) else $error("active count wrapped"); // R6

   AST_B_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !swap) |=> b_cnt == $past(b_cnt) + 1'b1) else $error("accept not counted"); // R4

endmodule

// File: rtl/dsp_pick_core.sv
module dsp_pick_core
   import dispatch_pkg::*;
#(
   parameter int NCORES  = 4,
   parameter int DEPTH   = 8,
   parameter int COST_W  = 16,
   localparam int CNT_W  = cnt_width(DEPTH),
   localparam int LOAD_W = load_width(COST_W, DEPTH)
)(
   input  logic [NCORES-1:0]        en,
   input  logic [NCORES*CNT_W-1:0]  bcnt,
   input  logic [NCORES*LOAD_W-1:0] bload,
   output logic                     found,
   output logic [NCORES-1:0]        pick
);

   logic [NCORES-1:0] eligible;

   genvar gi;
   generate
      for (gi = 0; gi < NCORES; gi++) begin : g_elig
         assign eligible[gi] = en[gi] && (bcnt[gi*CNT_W +: CNT_W] < CNT_W'(DEPTH));
      end
   endgenerate

   // Linear scan: strict less-than keeps the lowest index on a tie.
   always_comb begin
      logic [LOAD_W-1:0] best_load;
      int                best;
      found     = 1'b0;
      best_load = '0;
      best      = 0;
      for (int i = 0; i < NCORES; i++) begin
         if (eligible[i] && (!found || (bload[i*LOAD_W +: LOAD_W] < best_load))) begin
            found     = 1'b1;
            best_load = bload[i*LOAD_W +: LOAD_W];
            best      = i;
         end
      end
      pick = found ? (NCORES'(1) << best) : '0;
   end

endmodule

// File: rtl/dsp_core_budget.sv
module dsp_core_budget
   import dispatch_pkg::*;
#(
   parameter int NCORES  = 4,
   parameter int DEPTH   = 8,
   parameter int COST_W  = 16,
   localparam int LOAD_W = load_width(COST_W, DEPTH),
   localparam int SUM_W  = sum_width(COST_W, DEPTH, NCORES),
   localparam int EN_W   = $clog2(NCORES + 1)
)(
   input  logic [NCORES*LOAD_W-1:0] bload,
   input  logic [SUM_W-1:0]         budget,
   output logic [EN_W-1:0]          n_next
);

   localparam int PROD_W = SUM_W + $clog2(NCORES) + 1;

   logic [SUM_W-1:0]  total;
   logic [NCORES-1:0] over;

   always_comb begin
      total = '0;
      for (int i = 0; i < NCORES; i++) total = total + SUM_W'(bload[i*LOAD_W +: LOAD_W]);
   end

   // over[k] is set when the load exceeds k full budgets: core k is needed.
   genvar gk;
   generate
      for (gk = 0; gk < NCORES; gk++) begin : g_need
         assign over[gk] = PROD_W'(total) > (PROD_W'(gk) * PROD_W'(budget));
      end
   endgenerate

   always_comb begin
      logic [EN_W-1:0] cnt;
      cnt = '0;
      for (int k = 0; k < NCORES; k++) cnt = cnt + EN_W'(over[k]);
      n_next = (cnt == '0) ? EN_W'(1) : cnt;
   end

endmodule

// File: rtl/load_dispatcher.sv
module load_dispatcher
   import dispatch_pkg::*;
#(
   parameter int NCORES     = 4,
   parameter int NTYPES     = 8,
   parameter int DEPTH      = 8,
   parameter int COST_W     = 16,
   parameter int RESET_COST = 1,
   localparam int TYPE_W    = $clog2(NTYPES),
   localparam int CNT_W     = cnt_width(DEPTH),
   localparam int LOAD_W    = load_width(COST_W, DEPTH),
   localparam int SUM_W     = sum_width(COST_W, DEPTH, NCORES)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cost_we,
   input  logic [TYPE_W-1:0]        cost_addr,
   input  logic [COST_W-1:0]        cost_wdata,
   input  logic [SUM_W-1:0]         cycle_budget,
   input  logic                     cell_valid,
   input  logic [TYPE_W-1:0]        cell_type,
   output logic                     cell_ready,
   output logic [NCORES-1:0]        cell_dest,
   input  logic [NCORES-1:0]        a_done,
   output logic                     swap,
   output logic [NCORES-1:0]        core_en,
   output logic [NCORES*CNT_W-1:0]  a_count,
   output logic [NCORES*CNT_W-1:0]  b_count,
   output logic [NCORES*LOAD_W-1:0] b_load
);

   localparam int EN_W = $clog2(NCORES + 1);

   generate
      if (NCORES < 2)     begin : g_bad_cores $error("NCORES must be at least 2"); end
      if (NTYPES < 2)     begin : g_bad_types $error("NTYPES must be at least 2"); end
      if (DEPTH < 1)      begin : g_bad_depth $error("DEPTH must be at least 1"); end
      if (COST_W < 1)     begin : g_bad_cost  $error("COST_W must be at least 1"); end
      if (RESET_COST < 0) begin : g_bad_rc    $error("RESET_COST must not be negative"); end
   endgenerate

   logic [COST_W-1:0] cell_cost;
   logic              pick_found;
   logic [NCORES-1:0] pick_mask;
   logic [EN_W-1:0]   en_n_q;
   logic [EN_W-1:0]   en_n_next;
   logic              accept;
   logic              all_a_empty;
   logic              any_b_pending;

   dsp_cost_table #(
      .NTYPES(NTYPES), .COST_W(COST_W), .RESET_COST(RESET_COST)
   ) i_cost (
      .clk(clk), .rst_n(rst_n),
      .we(cost_we), .waddr(cost_addr), .wdata(cost_wdata),
      .raddr(cell_type), .rdata(cell_cost)
   );

   dsp_pick_core #(
      .NCORES(NCORES), .DEPTH(DEPTH), .COST_W(COST_W)
   ) i_pick (
      .en(core_en), .bcnt(b_count), .bload(b_load),
      .found(pick_found), .pick(pick_mask)
   );

   dsp_core_budget #(
      .NCORES(NCORES), .DEPTH(DEPTH), .COST_W(COST_W)
   ) i_budget (
      .bload(b_load), .budget(cycle_budget), .n_next(en_n_next)
   );

   genvar gc;
   generate
      for (gc = 0; gc < NCORES; gc++) begin : g_core
         dsp_core_track #(
            .DEPTH(DEPTH), .COST_W(COST_W)
         ) i_track (
            .clk(clk), .rst_n(rst_n),
            .accept(cell_dest[gc]), .cost(cell_cost),
            .done(a_done[gc]), .swap(swap),
            .a_cnt(a_count[gc*CNT_W +: CNT_W]),
            .b_cnt(b_count[gc*CNT_W +: CNT_W]),
            .b_load(b_load[gc*LOAD_W +: LOAD_W])
         );
         assign core_en[gc] = EN_W'(gc) < en_n_q;
      end
   endgenerate

   always_comb begin
      all_a_empty   = 1'b1;
      any_b_pending = 1'b0;
      for (int i = 0; i < NCORES; i++) begin
         if (a_count[i*CNT_W +: CNT_W] != '0) all_a_empty   = 1'b0;
         if (b_count[i*CNT_W +: CNT_W] != '0) any_b_pending = 1'b1;
      end
   end

   assign swap       = all_a_empty && any_b_pending;
   assign cell_ready = pick_found && !swap;
   assign accept     = cell_valid && cell_ready;
   assign cell_dest  = accept ? pick_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_n_q <= EN_W'(NCORES);
      else if (swap) en_n_q <= en_n_next;
   end

   AST_DEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cell_dest)) else $error("more than one destination"); // R3

   AST_DEST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_valid |-> cell_dest == '0) else $error("destination without item"); // R3

   AST_DEST_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_dest & ~core_en) == '0) else $error("item sent to disabled core"); // R9

   AST_SWAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> !swap) else $error("exchange longer than one cycle"); // R7

   AST_NO_ACCEPT_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      swap |-> !cell_ready) else $error("ready during exchange"); // R7

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> $stable(core_en)) else $error("enable changed off exchange"); // R8

   AST_EN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      core_en[0]) else $error("no core enabled"); // R8

endmodule

// File: tb/test_load_dispatcher.sv
module test_load_dispatcher;

   localparam int N    = 4;
   localparam int NT   = 8;
   localparam int D    = 8;
   localparam int CW   = 16;
   localparam int TW   = 3;
   localparam int CNTW = 4;
   localparam int LW   = 20;
   localparam int SW   = 22;
   localparam int WDOG = 150000;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cost_we;
   logic [TW-1:0]   cost_addr;
   logic [CW-1:0]   cost_wdata;
   logic [SW-1:0]   cycle_budget;
   logic            cell_valid;
   logic [TW-1:0]   cell_type;
   logic            cell_ready;
   logic [N-1:0]    cell_dest;
   logic [N-1:0]    a_done;
   logic            swap;
   logic [N-1:0]    core_en;
   logic [N*CNTW-1:0] a_count;
   logic [N*CNTW-1:0] b_count;
   logic [N*LW-1:0]   b_load;

   always #10 clk = ~clk;

   load_dispatcher #(.NCORES(N), .NTYPES(NT), .DEPTH(D), .COST_W(CW)) i_load_dispatcher (
      .clk(clk), .rst_n(rst_n),
      .cost_we(cost_we), .cost_addr(cost_addr), .cost_wdata(cost_wdata),
      .cycle_budget(cycle_budget),
      .cell_valid(cell_valid), .cell_type(cell_type),
      .cell_ready(cell_ready), .cell_dest(cell_dest),
      .a_done(a_done), .swap(swap), .core_en(core_en),
      .a_count(a_count), .b_count(b_count), .b_load(b_load)
   );

   int ma [N];
   int mb [N];
   int ml [N];
   int mcost [NT];
   int men;
   int n_chk = 0;
   int n_err = 0;
   int seen_swap = 0;
   int seen_full = 0;
   int min_en = N;
   bit finished = 1'b0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: compare at the falling edge, then advance as the rising edge will.
   always @(negedge clk) begin : ref_model
      int best, total, nn;
      bit sw, all_a, any_b, rdy;
      logic [N-1:0] exp_dest, exp_en;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin ma[i] = 0; mb[i] = 0; ml[i] = 0; end
         for (int t = 0; t < NT; t++) mcost[t] = 1;
         men = N;
      end else begin
         all_a = 1'b1; any_b = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (ma[i] != 0) all_a = 1'b0;
            if (mb[i] != 0) any_b = 1'b1;
         end
         sw = all_a && any_b;
         best = -1;
         for (int i = 0; i < N; i++)
            if (i < men && mb[i] < D && (best < 0 || ml[i] < ml[best])) best = i;
         rdy = !sw && (best >= 0);
         exp_dest = '0;
         if (cell_valid && rdy) exp_dest[best] = 1'b1;
         exp_en = '0;
         for (int i = 0; i < men; i++) exp_en[i] = 1'b1;

         chk("R7 swap", swap, sw);
         chk("R5 cell_ready", cell_ready, rdy);
         chk("R3 cell_dest", cell_dest, exp_dest);
         chk("R8 core_en", core_en, exp_en);
         chk("R9 dest inside enabled", cell_dest & ~core_en, 0);
         for (int i = 0; i < N; i++) begin
            chk("R6 a_count", a_count[i*CNTW +: CNTW], ma[i]);
            chk("R4 b_count", b_count[i*CNTW +: CNTW], mb[i]);
            chk("R4 R2 b_load", b_load[i*LW +: LW], ml[i]);
         end

         if (sw) seen_swap++;
         if (!sw && best < 0) seen_full++;
         if (men < min_en) min_en = men;

         if (sw) begin
            total = 0;
            for (int i = 0; i < N; i++) total += ml[i];
            if (total == 0) nn = 1;
            else if (cycle_budget == 0) nn = N;
            else nn = (total + int'(cycle_budget) - 1) / int'(cycle_budget);
            if (nn > N) nn = N;
            men = nn;
            for (int i = 0; i < N; i++) begin ma[i] = mb[i]; mb[i] = 0; ml[i] = 0; end
         end else begin
            for (int i = 0; i < N; i++) if (a_done[i] && ma[i] > 0) ma[i]--;
            if (cell_valid && rdy) begin
               mb[best]++;
               ml[best] += mcost[cell_type];
            end
         end
         if (cost_we) mcost[cost_addr] = int'(cost_wdata);
      end
   end

   task automatic drive(input bit v, input int ty, input logic [N-1:0] dn,
                        input bit we, input int addr, input int data);
      @(posedge clk);
      #2;
      cell_valid = v;
      cell_type  = TW'(ty);
      a_done     = dn;
      cost_we    = we;
      cost_addr  = TW'(addr);
      cost_wdata = CW'(data);
   endtask

   task automatic random_phase(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         logic [N-1:0] dn;
         for (int i = 0; i < N; i++) dn[i] = ($urandom_range(0, 9) < 3);
         drive($urandom_range(0, 9) < 7, $urandom_range(0, NT-1), dn,
               $urandom_range(0, 19) == 0, $urandom_range(0, NT-1), $urandom_range(1, 120));
      end
   endtask

   initial begin
      rst_n = 1'b0; cell_valid = 1'b0; cell_type = '0; a_done = '0;
      cost_we = 1'b0; cost_addr = '0; cost_wdata = '0; cycle_budget = SW'(1000);
      repeat (4) @(posedge clk);
      #2;
      // R1: values while reset is held
      chk("R1 swap in reset", swap, 0);
      chk("R1 ready in reset", cell_ready, 1);
      chk("R1 enable in reset", core_en, 4'hF);
      chk("R1 a_count in reset", a_count, 0);
      chk("R1 b_count in reset", b_count, 0);
      chk("R1 b_load in reset", b_load, 0);
      rst_n = 1'b1;

      // R1 default cost 1, R3 ties: first item of type 5 goes to core 0 with load 1
      drive(1, 5, '0, 0, 0, 0);
      drive(0, 0, '0, 0, 0, 0);
      #6;
      chk("R1 default cost", b_load[0 +: LW], 1);
      chk("R3 tie to core 0", b_count[0 +: CNTW], 1);
      // R7: that lone item triggers an exchange right now
      chk("R7 exchange after lone item", swap, 1);
      drive(0, 0, 4'b0001, 0, 0, 0);
      drive(0, 0, 4'b0001, 0, 0, 0); // R6: second pulse on an empty count is ignored
      drive(0, 0, '0, 0, 0, 0);
      #6;
      chk("R6 no wrap below zero", a_count[0 +: CNTW], 0);

      // R2: program a cost table
      for (int t = 0; t < NT; t++) drive(0, 0, '0, 1, t, 10 * (t + 1));

      random_phase(300);                          // R3 R4 R6 R7 mixed traffic
      for (int c = 0; c < 60; c++) drive(1, c % NT, '0, 0, 0, 0);  // R5 fill
      for (int c = 0; c < 40; c++) drive(0, 0, '1, 0, 0, 0);       // R7 drain and exchange
      cycle_budget = SW'(100000);                  // R8 huge budget: one core
      random_phase(300);
      for (int c = 0; c < 30; c++) drive(1, 7, '0, 0, 0, 0);
      for (int c = 0; c < 40; c++) drive(0, 0, '1, 0, 0, 0);
      cycle_budget = SW'(50);                      // R8 small budget: all cores
      random_phase(300);
      cycle_budget = SW'(0);                       // R8 zero budget
      random_phase(100);
      drive(0, 0, '0, 0, 0, 0);
      @(negedge clk);

      chk("R7 exchanges observed", seen_swap > 3, 1);
      chk("R5 full condition observed", seen_full > 0, 1);
      chk("R8 single core observed", min_en, 1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R7 actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule